// File: doc/BRIEF.md
# Banked Scratchpad RAM Controller

This block owns the 256-byte internal data memory of an 8-bit microcontroller core. It accepts one request per cycle from the core and serves the different ways the core reaches that memory. Direct byte addressing covers the lower half of RAM, and addresses from 80h upward go out to the special-function-register (SFR) port. Working registers R0–R7 are translated through a two-bit bank select. Indirect addressing uses R0 or R1 of the current bank as a pointer into all 256 bytes. Single-bit reads and read-modify-write bit updates cover both the bit window in RAM and the bit-capable SFRs. Stack push and pop use an internal pre-increment stack pointer.

Read results come back one cycle after the request is accepted, with a valid strobe. A bit write takes two cycles. During its second cycle `busy` is high and any new request is dropped. The stack pointer is shown on `sp_out`. The core can read and write it as SFR 81h, and those accesses never reach the external SFR port.

Top module: `scratch_ram_ctl`

## Requirements
- R1: After synchronous reset, `sp_out` is 07h, `busy` and `rd_valid` are low, and every RAM byte reads as 00h.
- R2: Direct read (op 1) and direct write (op 2) at an address below 80h access that RAM byte. The read result appears on `rd_data[7:0]` with `rd_valid` high in the cycle after acceptance, and `rd_data[15:8]` is zero.
- R3: A direct read or write at an address of 80h or above, other than 81h, is carried out on the SFR port (`sfr_rd`/`sfr_wr`, `sfr_addr` equal to the request address) and leaves RAM unchanged.
- R4: Register read (op 3) and register write (op 4) with register number n = `req_addr[2:0]` and bank b = `bank_sel` access RAM byte b*8+n.
- R5: Indirect read (op 5) and indirect write (op 6) use the byte held in R0 (`req_addr[0]`=0) or R1 (`req_addr[0]`=1) of the current bank as the RAM address, and reach all 256 bytes, including 80h–FFh.
- R6: Bit read (op 7) at a bit address below 80h returns, on `rd_bit`, bit `a[2:0]` of RAM byte 20h + (a >> 3).
- R7: A bit access at a bit address of 80h or above targets SFR byte (a & F8h), bit `a[2:0]`, through the SFR port.
- R8: A bit write (op 8) changes only the selected bit, setting it to `req_bitval`, and leaves the other seven bits as they were. `busy` is high in exactly the one cycle after acceptance, and a request presented in that cycle has no effect.
- R9: Push (op 9) first increments SP and then stores `req_wdata` at the new SP. Pop (op 10) returns the byte at SP and then decrements SP. SP wraps modulo 256.
- R10: A call push (op 11) stores `req_wdata` (the low byte) at SP+1 and `req_addr` (the high byte) at SP+2, then adds 2 to SP. A return pop (op 12) returns {byte at SP, byte at SP−1} on `rd_data[15:0]` and subtracts 2 from SP.
- R11: A direct read at 81h returns SP and a direct write at 81h loads SP. Neither access produces any activity on the SFR port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | 8 | Byte address, bit address, register number, or call high byte |
| req_wdata | input | 8 | Write data, push data, or call low byte |
| req_bitval | input | 1 | Value written by a bit write |
| bank_sel | input | 2 | Working-register bank select |
| busy | output | 1 | Second cycle of a bit write; requests are ignored |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result (16 bits only for a return pop) |
| rd_bit | output | 1 | Bit read result |
| sp_out | output | 8 | Current stack pointer |
| sfr_addr | output | 8 | SFR port address |
| sfr_rd | output | 1 | SFR read strobe (data sampled from `sfr_rdata` in the same cycle) |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, combinational from `sfr_addr` |

## Verification
Two functions can meet in one cycle: the write-back half of a bit read-modify-write and a newly presented request. The bench holds a direct RAM write on the request port during the `busy` cycle of a bit write. It then reads both the bit-write target and the address of the dropped write back through the normal interface. The test passes only if the bit update landed and the other byte still reads 00h. A second overlap appears when the stack pointer is loaded through SFR address 81h and then wraps on the next pushes. This is judged from `sp_out`, from the popped data, and from the bench's SFR model, which must never see address 81h.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int DEPTH     = 1 << AW;
    localparam int BANK_W    = 2;
    localparam int REGN_W    = 3;
    localparam int BITIDX_W  = 3;

    typedef logic [DW-1:0]       byte_t;
    typedef logic [AW-1:0]       addr_t;
    typedef logic [BITIDX_W-1:0] bidx_t;

    localparam addr_t BIT_WIN_BASE = 8'h20;
    localparam addr_t DIRECT_TOP   = 8'h80;
    localparam addr_t SP_SFR_ADDR  = 8'h81;
    localparam addr_t SP_RESET     = 8'h07;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_DIR_RD = 4'd1,
        OP_DIR_WR = 4'd2,
        OP_REG_RD = 4'd3,
        OP_REG_WR = 4'd4,
        OP_IND_RD = 4'd5,
        OP_IND_WR = 4'd6,
        OP_BIT_RD = 4'd7,
        OP_BIT_WR = 4'd8,
        OP_PUSH   = 4'd9,
        OP_POP    = 4'd10,
        OP_CALL   = 4'd11,
        OP_RET    = 4'd12
    } op_e;

    typedef enum logic [2:0] {
        SP_HOLD, SP_INC1, SP_INC2, SP_DEC1, SP_DEC2, SP_LOAD
    } sp_act_e;

    typedef struct packed {
        logic  in_sfr;
        addr_t byte_addr;
        bidx_t idx;
    } bit_loc_t;

    // Bit space: lower half lands in the RAM bit window, upper half on SFRs at multiples of 8
    function automatic bit_loc_t map_bit(addr_t a);
        bit_loc_t r;
        r.idx = a[BITIDX_W-1:0];
        if (a[AW-1]) begin
            r.in_sfr    = 1'b1;
            r.byte_addr = {a[AW-1:BITIDX_W], {BITIDX_W{1'b0}}};
        end else begin
            r.in_sfr    = 1'b0;
            r.byte_addr = BIT_WIN_BASE + addr_t'(a[AW-2:BITIDX_W]);
        end
        return r;
    endfunction

    function automatic addr_t reg_phys(logic [BANK_W-1:0] b, logic [REGN_W-1:0] n);
        return addr_t'({b, n});
    endfunction

    function automatic byte_t put_bit(byte_t v, bidx_t i, logic val);
        byte_t r;
        r    = v;
        r[i] = val;
        return r;
    endfunction

    function automatic logic is_read(op_e op);
        return op inside {OP_DIR_RD, OP_REG_RD, OP_IND_RD, OP_BIT_RD, OP_POP, OP_RET};
    endfunction

endpackage

// File: rtl/sram_store.sv
module sram_store
    import sram_pkg::*;
#(
    parameter int A_W = AW,
    parameter int D_W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] ra_addr,
    output logic [D_W-1:0] ra_data,
    input  logic [A_W-1:0] rb_addr,
    output logic [D_W-1:0] rb_data,
    input  logic           wa_en,
    input  logic [A_W-1:0] wa_addr,
    input  logic [D_W-1:0] wa_data,
    input  logic           wb_en,
    input  logic [A_W-1:0] wb_addr,
    input  logic [D_W-1:0] wb_data
);
    localparam int N = 1 << A_W;

    logic [D_W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else begin
            if (wa_en) mem[wa_addr] <= wa_data;
            if (wb_en) mem[wb_addr] <= wb_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/sram_sp.sv
module sram_sp
    import sram_pkg::*;
#(
    parameter addr_t INIT = SP_RESET
) (
    input  logic    clk,
    input  logic    rst,
    input  sp_act_e act,
    input  addr_t   load_val,
    output addr_t   sp,
    output addr_t   sp_p1,
    output addr_t   sp_p2,
    output addr_t   sp_m1
);
    assign sp_p1 = sp + addr_t'(1);
    assign sp_p2 = sp + addr_t'(2);
    assign sp_m1 = sp - addr_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= INIT;
        end else begin
            unique case (act)
                SP_INC1: sp <= sp_p1;
                SP_INC2: sp <= sp_p2;
                SP_DEC1: sp <= sp_m1;
                SP_DEC2: sp <= sp - addr_t'(2);
                SP_LOAD: sp <= load_val;
                default: sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/scratch_ram_ctl.sv
module scratch_ram_ctl
    import sram_pkg::*;
#(
    parameter logic [7:0] SP_INIT = SP_RESET
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        req_bitval,
    input  logic [1:0]  bank_sel,
    output logic        busy,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        rd_bit,
    output logic [7:0]  sp_out,
    output logic [7:0]  sfr_addr,
    output logic        sfr_rd,
    output logic        sfr_wr,
    output logic [7:0]  sfr_wdata,
    input  logic [7:0]  sfr_rdata
);
    op_e      op;
    logic     accept;
    bit_loc_t bl;
    addr_t    rn_addr, ptr_reg;
    logic     dir_sp, dir_sfr;

    addr_t    ra_addr, rb_addr, wa_addr, wb_addr;
    byte_t    ra_data, rb_data, wa_data, wb_data;
    logic     wa_en, wb_en;

    sp_act_e  sp_act;
    addr_t    sp, sp_p1, sp_p2, sp_m1;

    // Pending write-back of a bit read-modify-write
    logic     hold_sfr;
    addr_t    hold_addr;
    byte_t    hold_byte;
    byte_t    bit_src;

    assign op      = op_e'(req_op);
    assign accept  = req_valid && !busy;
    assign bl      = map_bit(req_addr);
    assign rn_addr = reg_phys(bank_sel, req_addr[REGN_W-1:0]);
    assign ptr_reg = reg_phys(bank_sel, {2'b00, req_addr[0]});
    assign dir_sp  = (req_addr == SP_SFR_ADDR);
    assign dir_sfr = (req_addr >= DIRECT_TOP) && !dir_sp;
    assign bit_src = bl.in_sfr ? sfr_rdata : ra_data;

    sram_store #(.A_W(AW), .D_W(DW)) i_store (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (wb_data)
    );

    sram_sp #(.INIT(SP_INIT)) i_sp (
        .clk      (clk),
        .rst      (rst),
        .act      (sp_act),
        .load_val (req_wdata),
        .sp       (sp),
        .sp_p1    (sp_p1),
        .sp_p2    (sp_p2),
        .sp_m1    (sp_m1)
    );

    assign sp_out = sp;

    // Read port selection; port B chains off port A for indirect access
    always_comb begin
        unique case (op)
            OP_REG_RD, OP_REG_WR: ra_addr = rn_addr;
            OP_IND_RD, OP_IND_WR: ra_addr = ptr_reg;
            OP_POP, OP_RET:       ra_addr = sp;
            OP_BIT_RD, OP_BIT_WR: ra_addr = bl.byte_addr;
            default:              ra_addr = req_addr;
        endcase
        rb_addr = (op == OP_RET) ? sp_m1 : ra_data;
    end

    // RAM writes and stack pointer action
    always_comb begin
        wa_en   = 1'b0;
        wa_addr = req_addr;
        wa_data = req_wdata;
        wb_en   = 1'b0;
        wb_addr = sp_p2;
        wb_data = req_addr;
        sp_act  = SP_HOLD;
        if (busy) begin
            wa_en   = !hold_sfr;
            wa_addr = hold_addr;
            wa_data = hold_byte;
        end else if (accept) begin
            unique case (op)
                OP_DIR_WR: begin
                    wa_en  = (req_addr < DIRECT_TOP);
                    sp_act = dir_sp ? SP_LOAD : SP_HOLD;
                end
                OP_REG_WR: begin
                    wa_en   = 1'b1;
                    wa_addr = rn_addr;
                end
                OP_IND_WR: begin
                    wa_en   = 1'b1;
                    wa_addr = ra_data;
                end
                OP_PUSH: begin
                    wa_en   = 1'b1;
                    wa_addr = sp_p1;
                    sp_act  = SP_INC1;
                end
                OP_CALL: begin
                    wa_en   = 1'b1;
                    wa_addr = sp_p1;
                    wb_en   = 1'b1;
                    sp_act  = SP_INC2;
                end
                OP_POP:  sp_act = SP_DEC1;
                OP_RET:  sp_act = SP_DEC2;
                default: ;
            endcase
        end
    end

    // SFR port
    always_comb begin
        sfr_rd    = 1'b0;
        sfr_wr    = 1'b0;
        sfr_addr  = req_addr;
        sfr_wdata = req_wdata;
        if (busy) begin
            sfr_wr    = hold_sfr;
            sfr_addr  = hold_addr;
            sfr_wdata = hold_byte;
        end else if (accept) begin
            unique case (op)
                OP_DIR_RD: sfr_rd = dir_sfr;
                OP_DIR_WR: sfr_wr = dir_sfr;
                OP_BIT_RD, OP_BIT_WR: begin
                    sfr_rd   = bl.in_sfr;
                    sfr_addr = bl.byte_addr;
                end
                default: ;
            endcase
        end
    end

    // Result and bit-write sequencing registers
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            hold_sfr  <= 1'b0;
            hold_addr <= '0;
            hold_byte <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_bit    <= 1'b0;
        end else begin
            rd_valid <= accept && is_read(op);
            busy     <= accept && (op == OP_BIT_WR);
            if (accept && op == OP_BIT_WR) begin
                hold_sfr  <= bl.in_sfr;
                hold_addr <= bl.byte_addr;
                hold_byte <= put_bit(bit_src, bl.idx, req_bitval);
            end
            if (accept) begin
                unique case (op)
                    OP_DIR_RD: rd_data <= {8'h00, dir_sp ? sp : (dir_sfr ? sfr_rdata : ra_data)};
                    OP_REG_RD: rd_data <= {8'h00, ra_data};
                    OP_IND_RD: rd_data <= {8'h00, rb_data};
                    OP_POP:    rd_data <= {8'h00, ra_data};
                    OP_RET:    rd_data <= {ra_data, rb_data};
                    OP_BIT_RD: rd_bit  <= bit_src[bl.idx];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] req_op,
    input logic [7:0] req_addr,
    input logic       busy,
    input logic       rd_valid,
    input logic [7:0] sp_out,
    input logic [7:0] sfr_addr,
    input logic       sfr_rd,
    input logic       sfr_wr
);
    logic take;
    assign take = req_valid && !busy;

    // R1
    sp_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp_out == 8'h07 && !busy && !rd_valid));

    // R2
    rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (req_op == 4'd1 || req_op == 4'd3 || req_op == 4'd5 ||
                  req_op == 4'd7 || req_op == 4'd10 || req_op == 4'd12)) |=> rd_valid);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 4'd8) |=> busy);

    // R8
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R8
    busy_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!sfr_rd && !rd_valid));

    // R9
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 4'd9) |=> sp_out == $past(sp_out) + 8'd1);

    // R9
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 4'd10) |=> sp_out == $past(sp_out) - 8'd1);

    // R10
    call_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 4'd11) |=> sp_out == $past(sp_out) + 8'd2);

    // R11
    sp_private_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_rd || sfr_wr) |-> sfr_addr != 8'h81);

    // R7
    sfr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sfr_rd, sfr_wr}));

    // R3
    sfr_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !busy) |-> !sfr_wr);
endmodule

bind scratch_ram_ctl sram_ctl_chk i_chk (.*);

// File: tb/test_scratch_ram_ctl.sv
module test_scratch_ram_ctl;
    localparam logic [3:0] DRD = 4'd1, DWR = 4'd2, RRD = 4'd3, RWR = 4'd4,
                           IRD = 4'd5, IWR = 4'd6, BRD = 4'd7, BWR = 4'd8,
                           PSH = 4'd9, POP = 4'd10, CAL = 4'd11, RET = 4'd12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_bitval = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic        busy, rd_valid, rd_bit, sfr_rd, sfr_wr;
    logic [15:0] rd_data;
    logic [7:0]  sp_out, sfr_addr, sfr_wdata, sfr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int sp81_hits = 0;
    logic [7:0]  sfr_mem [256];
    logic [16:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    scratch_ram_ctl i_scratch_ram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bitval(req_bitval),
        .bank_sel(bank_sel), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_bit(rd_bit), .sp_out(sp_out), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
        .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // SFR register file model
    initial for (int i = 0; i < 256; i++) sfr_mem[i] = 8'h00;
    assign sfr_rdata = sfr_mem[sfr_addr];
    always @(posedge clk) begin
        if (!rst && sfr_wr) sfr_mem[sfr_addr] <= sfr_wdata;
        if (!rst && (sfr_wr || sfr_rd) && sfr_addr == 8'h81) sp81_hits++;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design reports them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected rd_valid", 1, 0);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[16]) check(rd_bit == e[0], t, rd_bit, e[0]);
                else       check(rd_data == e[15:0], t, rd_data, e[15:0]);
            end
        end
    end

    // Driver: one request, expected result queued for read operations
    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic bv, input logic [1:0] bk,
                         input logic [16:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        req_bitval = bv; bank_sel = bk;
        if (op inside {DRD, RRD, IRD, BRD, POP, RET}) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (op == BWR) @(negedge clk);
    endtask

    task automatic chk_sp(input logic [7:0] e, input string tag);
        check(sp_out == e, tag, sp_out, e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_sp(8'h07, "R1 sp after reset");
        check(!busy, "R1 busy after reset", busy, 0);
        check(!rd_valid, "R1 rd_valid after reset", rd_valid, 0);
        issue(DRD, 8'h30, 0, 0, 0, 17'h0, "R1 ram cleared");

        // R2 direct RAM
        issue(DWR, 8'h30, 8'hA5, 0, 0, 0, "");
        issue(DRD, 8'h30, 0, 0, 0, 17'h00A5, "R2 direct 30h");
        issue(DWR, 8'h7F, 8'h3C, 0, 0, 0, "");
        issue(DRD, 8'h7F, 0, 0, 0, 17'h003C, "R2 direct 7Fh");

        // R3 direct SFR
        issue(DWR, 8'h90, 8'h5A, 0, 0, 0, "");
        check(sfr_mem[8'h90] == 8'h5A, "R3 sfr write", sfr_mem[8'h90], 8'h5A);
        issue(DRD, 8'h90, 0, 0, 0, 17'h005A, "R3 sfr read");

        // R4 working registers
        issue(RWR, 8'h05, 8'h11, 0, 2'd2, 0, "");
        issue(DRD, 8'h15, 0, 0, 0, 17'h0011, "R4 bank2 R5 at 15h");
        issue(RWR, 8'h03, 8'h22, 0, 2'd0, 0, "");
        issue(DRD, 8'h03, 0, 0, 0, 17'h0022, "R4 bank0 R3 at 03h");
        issue(DWR, 8'h1F, 8'h77, 0, 0, 0, "");
        issue(RRD, 8'h07, 0, 0, 2'd3, 17'h0077, "R4 bank3 R7 reads 1Fh");

        // R5 indirect
        issue(RWR, 8'h00, 8'h90, 0, 2'd1, 0, "");
        issue(IRD, 8'h00, 0, 0, 2'd1, 17'h0000, "R3 upper RAM untouched by sfr write");
        issue(IWR, 8'h00, 8'hC3, 0, 2'd1, 0, "");
        issue(IRD, 8'h00, 0, 0, 2'd1, 17'h00C3, "R5 indirect upper RAM");
        issue(DRD, 8'h90, 0, 0, 0, 17'h005A, "R3 direct 90h still sfr");
        issue(RWR, 8'h01, 8'h40, 0, 2'd1, 0, "");
        issue(IWR, 8'h01, 8'h99, 0, 2'd1, 0, "");
        issue(DRD, 8'h40, 0, 0, 0, 17'h0099, "R5 via R1");

        // R6 / R8 RAM bits
        issue(BWR, 8'h7F, 0, 1'b1, 0, 0, "");
        issue(DRD, 8'h2F, 0, 0, 0, 17'h0080, "R8 bit 7F sets 2Fh.7");
        issue(DWR, 8'h21, 8'hFF, 0, 0, 0, "");
        // R8 bit write with a request held during busy
        @(negedge clk);
        req_valid = 1'b1; req_op = BWR; req_addr = 8'h0B; req_bitval = 1'b0; bank_sel = 0;
        @(posedge clk);
        @(negedge clk);
        check(busy, "R8 busy in second cycle", busy, 1);
        req_op = DWR; req_addr = 8'h31; req_wdata = 8'hEE;
        @(posedge clk);
        @(negedge clk);
        check(!busy, "R8 busy drops", busy, 0);
        req_valid = 1'b0;
        issue(DRD, 8'h31, 0, 0, 0, 17'h0000, "R8 request during busy ignored");
        issue(DRD, 8'h21, 0, 0, 0, 17'h00F7, "R8 only bit 3 cleared");
        issue(BRD, 8'h0C, 0, 0, 0, 17'h10001, "R6 bit 0Ch reads 1");
        issue(BRD, 8'h0B, 0, 0, 0, 17'h10000, "R6 bit 0Bh reads 0");

        // R7 SFR bits
        issue(DWR, 8'h88, 8'h0F, 0, 0, 0, "");
        issue(BWR, 8'h8E, 0, 1'b1, 0, 0, "");
        issue(DRD, 8'h88, 0, 0, 0, 17'h004F, "R7 sfr 88h bit6 set");
        issue(BRD, 8'h8A, 0, 0, 0, 17'h10001, "R7 sfr 88h bit2 read");
        issue(BWR, 8'h91, 0, 1'b0, 0, 0, "");
        issue(DRD, 8'h90, 0, 0, 0, 17'h0058, "R7 sfr 90h bit1 cleared");

        // R9 push/pop
        issue(PSH, 0, 8'hAB, 0, 0, 0, "");
        chk_sp(8'h08, "R9 sp after push");
        issue(DRD, 8'h08, 0, 0, 0, 17'h00AB, "R9 push stored at new sp");
        issue(PSH, 0, 8'hCD, 0, 0, 0, "");
        issue(POP, 0, 0, 0, 0, 17'h00CD, "R9 pop newest");
        chk_sp(8'h08, "R9 sp after pop");
        issue(POP, 0, 0, 0, 0, 17'h00AB, "R9 pop older");
        chk_sp(8'h07, "R9 sp back to 07");

        // R11 SP as SFR 81h
        issue(DRD, 8'h81, 0, 0, 0, 17'h0007, "R11 read sp");
        issue(DWR, 8'h81, 8'hFE, 0, 0, 0, "");
        chk_sp(8'hFE, "R11 sp loaded");

        // R9 wrap
        issue(PSH, 0, 8'h12, 0, 0, 0, "");
        issue(PSH, 0, 8'h34, 0, 0, 0, "");
        chk_sp(8'h00, "R9 sp wraps to 00");
        issue(DRD, 8'h00, 0, 0, 0, 17'h0034, "R9 wrapped push at 00h");
        issue(POP, 0, 0, 0, 0, 17'h0034, "R9 pop after wrap");
        chk_sp(8'hFF, "R9 sp wraps to FF");

        // R10 call/return
        issue(CAL, 8'h78, 8'h56, 0, 0, 0, "");
        chk_sp(8'h01, "R10 sp after call");
        issue(DRD, 8'h00, 0, 0, 0, 17'h0056, "R10 low byte first");
        issue(DRD, 8'h01, 0, 0, 0, 17'h0078, "R10 high byte second");
        issue(RET, 0, 0, 0, 0, 17'h7856, "R10 return pair");
        chk_sp(8'hFF, "R10 sp after return");

        repeat (4) @(negedge clk);
        check(sp81_hits == 0, "R11 no sfr port access at 81h", sp81_hits, 0);
        check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule